// File: doc/BRIEF.md
# Multichannel Prescaled PWM Peripheral

This peripheral drives a set of pulse-width-modulated outputs. All of them share one 8-bit period counter and one clock prescaler. The counter advances once per local tick, and the local tick runs at the input clock rate divided by the prescale setting plus one. A period is therefore always 256 local ticks long, and the only way to stretch it is the 4-bit prescale setting. Each channel compares the shared count with its own duty value. The output is high for the duty value plus one ticks. A duty of zero still gives a single-tick pulse, and a duty of 255 keeps the line high for the whole period.

Software programs the block through a simple request port carrying valid, write, byte address and 32-bit data. Read data comes back one cycle after the request. Duty and prescale writes land in shadow storage. They are copied into the working set only when the counter wraps from 255 to 0, so a period in progress is never cut or stretched. A global enable starts and freezes the counter. While the enable is clear, every output is low.

Top module: `pwm_multi`

## Requirements
- R1: After reset every output is low, the counter reads 0, and every register reads 0.
- R2: With prescale p in effect, one PWM period lasts exactly 256*(p+1) input clock cycles. The counter steps by at most one per cycle and wraps from 255 to 0.
- R3: With duty d and prescale p in effect, a channel output is high for (d+1)*(p+1) consecutive cycles per period. d = 0 gives one tick, and every output is high while the counter is 0.
- R4: A channel with duty 255 stays high for the whole period and never goes low while enabled.
- R5: Register map. Channel n's duty is bits [7:0] at byte offset 4*n. The control word is at 0x50, with prescale in bits [3:0] and enable in bit 9. Interrupt enable is bit 0 at 0x54. The counter is bits [7:0] at 0x58 and is read-only. Unused bits read 0. Read data appears on rd_data with rd_valid high in the cycle after a read request.
- R6: Writes to unmapped or misaligned offsets, and to the counter, change nothing. Reads of unmapped offsets return 0.
- R7: Clearing enable drives all outputs low and freezes the counter at its value. Setting enable again resumes counting from that value.
- R8: A duty or prescale write takes effect only at the next counter wrap. The period in progress keeps its old high time.
- R9: Channels are independent: each output follows only its own duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The hardest situation to reach is a duty write that lands in the middle of a long, prescaled period. The new value must not reach the output until the wrap. The bench synchronises on a rising edge of the channel, which coincides with the wrap. It then issues the write one cycle later and counts the remaining high cycles, so the high time of the current period can be compared with the old value and that of the next period with the new one. A second hard case is a freeze and resume with a nonzero prescale. The bench reads the counter before and after a long disabled stretch, then confirms that counting resumes near the frozen value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 4;
    localparam int EN_BIT = 9;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_IRQ  = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h58;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PRE_W-1:0]  pre_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DUTY,
        SEL_CTRL,
        SEL_IRQ,
        SEL_CNT
    } reg_sel_e;

    typedef struct packed {
        logic en;
        pre_t pre;
        logic irq_en;
    } cfg_t;

    function automatic reg_sel_e decode_sel(addr_t addr, int nch);
        if (addr[1:0] != 2'b00)       return SEL_NONE;
        if (int'(addr) < 4 * nch)     return SEL_DUTY;
        if (addr == OFF_CTRL)         return SEL_CTRL;
        if (addr == OFF_IRQ)          return SEL_IRQ;
        if (addr == OFF_CNT)          return SEL_CNT;
        return SEL_NONE;
    endfunction

    function automatic word_t ctrl_word(cfg_t c);
        word_t w;
        w = '0;
        w[PRE_W-1:0] = c.pre;
        w[EN_BIT]    = c.en;
        return w;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  addr_t                         req_addr,
    input  word_t                         req_wdata,
    input  cnt_t                          cnt_q,
    output cfg_t                          cfg,
    output logic [NUM_CH-1:0][CNT_W-1:0]  duty_sh,
    output logic                          rd_valid,
    output word_t                         rd_data
);
    localparam int IDX_W = ADDR_W - 2;

    reg_sel_e           sel;
    logic               wr_en;
    logic               rd_en;
    logic [IDX_W-1:0]   word_idx;
    word_t              rd_mux;
    logic               unused_wbits;

    assign sel          = decode_sel(req_addr, NUM_CH);
    assign wr_en        = req_valid && req_write;
    assign rd_en        = req_valid && !req_write;
    assign word_idx     = req_addr[ADDR_W-1:2];
    assign unused_wbits = ^{req_wdata[DATA_W-1:EN_BIT+1], req_wdata[EN_BIT-1:CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    cfg.en  <= req_wdata[EN_BIT];
                    cfg.pre <= req_wdata[PRE_W-1:0];
                end
                SEL_IRQ:  cfg.irq_en <= req_wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_sh <= '0;
        end else if (wr_en && sel == SEL_DUTY) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (word_idx == IDX_W'(i))
                    duty_sh[i] <= req_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_DUTY: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (word_idx == IDX_W'(i))
                        rd_mux[CNT_W-1:0] = duty_sh[i];
                end
            end
            SEL_CTRL: rd_mux = ctrl_word(cfg);
            SEL_IRQ:  rd_mux[0] = cfg.irq_en;
            SEL_CNT:  rd_mux[CNT_W-1:0] = cnt_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  pre_t pre_sh,
    output cnt_t cnt_q,
    output logic wrap
);
    pre_t pre_cnt;
    pre_t pre_act;
    logic tick;

    assign tick = en && (pre_cnt == pre_act);
    assign wrap = tick && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            pre_act <= '0;
            cnt_q   <= '0;
        end else if (en) begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick)
                cnt_q <= cnt_q + 1'b1;
            if (wrap)
                pre_act <= pre_sh;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic wrap,
    input  cnt_t cnt_q,
    input  cnt_t duty_sh,
    output logic out
);
    cnt_t duty_act;

    always_ff @(posedge clk) begin
        if (rst)
            duty_act <= '0;
        else if (wrap)
            duty_act <= duty_sh;
    end

    assign out = en && (cnt_q <= duty_act);

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [7:0]         req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic [NUM_CH-1:0]  pwm_out
);
    cfg_t                          cfg;
    logic [NUM_CH-1:0][CNT_W-1:0]  duty_sh;
    cnt_t                          cnt_q;
    logic                          wrap;
    logic                          en_w;

    assign en_w = cfg.en;

    pwm_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cnt_q     (cnt_q),
        .cfg       (cfg),
        .duty_sh   (duty_sh),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    pwm_timebase u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (en_w),
        .pre_sh (cfg.pre),
        .cnt_q  (cnt_q),
        .wrap   (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
        pwm_chan u_ch (
            .clk     (clk),
            .rst     (rst),
            .en      (en_w),
            .wrap    (wrap),
            .cnt_q   (cnt_q),
            .duty_sh (duty_sh[g]),
            .out     (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              en_w,
    input cnt_t              cnt_q,
    input logic              req_valid,
    input logic              req_write,
    input logic              rd_valid,
    input logic [NUM_CH-1:0] pwm_out
);
    // R7: outputs low whenever the enable is clear
    a_r7_outputs_low_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_w |-> pwm_out == '0);

    // R7: counter holds while disabled
    a_r7_counter_frozen: assert property (@(posedge clk) disable iff (rst)
        !en_w |=> $stable(cnt_q));

    // R2: counter advances by at most one per cycle (with wrap)
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));

    // R3: every channel is high while the counter is 0
    a_r3_high_at_zero: assert property (@(posedge clk) disable iff (rst)
        (en_w && cnt_q == '0) |-> (&pwm_out));

    // R8: with no count movement and steady enable, outputs do not change
    a_r8_no_change_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (en_w && $past(en_w) && cnt_q == $past(cnt_q)) |-> $stable(pwm_out));

    // R5: read response one cycle after a read request, and only then
    a_r5_read_response: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);
    a_r5_no_spurious_read: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);

endmodule

bind pwm_multi pwm_multi_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_w      (en_w),
    .cnt_q     (cnt_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .rd_valid  (rd_valid),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_multi_test.sv
module pwm_multi_test;
    localparam int NCH = 3;
    localparam int LIM = 5000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [7:0]      req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic [NCH-1:0]  pwm_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    pwm_multi #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!rd_valid) begin
            checks++; failures++;
            $display("FAIL R5 rd_valid: actual=0 expected=1");
        end
        d = rd_data;
    endtask

    task automatic wait_rise(int ch);
        int n = 0;
        @(negedge clk);
        while (pwm_out[ch] && n < LIM) begin @(negedge clk); n++; end
        while (!pwm_out[ch] && n < 2 * LIM) begin @(negedge clk); n++; end
    endtask

    task automatic measure(int ch, output int hi, output int lo);
        wait_rise(ch);
        hi = 0; lo = 0;
        while (pwm_out[ch] && hi < LIM) begin hi++; @(negedge clk); end
        while (!pwm_out[ch] && lo < LIM) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "outputs after reset", 32'(pwm_out), 0);
        bus_read(8'h00, d); check("R1", "duty0 after reset", d, 0);
        bus_read(8'h50, d); check("R1", "control after reset", d, 0);
        bus_read(8'h54, d); check("R1", "irq enable after reset", d, 0);
        bus_read(8'h58, d); check("R1", "counter after reset", d, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        bus_write(8'h00, 32'hFFFF_FF5A);
        bus_read(8'h00, d);  check("R5", "duty0 keeps bits 7:0 only", d, 32'h5A);
        bus_write(8'h08, 32'h0000_0011);
        bus_read(8'h08, d);  check("R5", "duty2 at offset 8", d, 32'h11);
        bus_write(8'h50, 32'h0000_FDF3);
        bus_read(8'h50, d);  check("R5", "control prescale bits, enable clear", d, 32'h3);
        bus_write(8'h54, 32'hFFFF_FFFF);
        bus_read(8'h54, d);  check("R5", "irq enable bit 0", d, 32'h1);
        bus_write(8'h54, 32'h0);
        bus_read(8'h54, d);  check("R5", "irq enable cleared", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h0C, 32'hAB);
        bus_write(8'h5C, 32'hFFFF_FFFF);
        bus_write(8'h51, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'h77);
        bus_write(8'h58, 32'h42);
        bus_read(8'h0C, d); check("R6", "beyond last channel reads 0", d, 0);
        bus_read(8'h5C, d); check("R6", "unmapped reads 0", d, 0);
        bus_read(8'h00, d); check("R6", "duty0 untouched", d, 32'h5A);
        bus_read(8'h50, d); check("R6", "control untouched by misaligned write", d, 32'h3);
        bus_read(8'h58, d); check("R6", "counter not writable", d, 0);
        check("R6", "outputs still low", 32'(pwm_out), 0);
    endtask

    task automatic t_base_patterns();
        int hi, lo;
        bus_write(8'h00, 32'd0);
        bus_write(8'h04, 32'd100);
        bus_write(8'h08, 32'd255);
        bus_write(8'h50, 32'h0000_0200);
        measure(0, hi, lo);
        check("R3", "duty 0 high ticks", hi, 1);
        check("R2", "period prescale 0", hi + lo, 256);
        measure(1, hi, lo);
        check("R3", "duty 100 high ticks", hi, 101);
        check("R9", "channel 1 low ticks", lo, 155);
    endtask

    task automatic t_full_duty();
        int low_seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (!pwm_out[2]) low_seen++;
        end
        check("R4", "duty 255 low samples", low_seen, 0);
    endtask

    task automatic t_prescale();
        int hi, lo;
        bus_write(8'h50, 32'h0000_0203);
        measure(1, hi, lo);
        check("R2", "period prescale 3", hi + lo, 1024);
        check("R3", "high time prescale 3", hi, 404);
    endtask

    task automatic t_deferred();
        int hi, lo;
        wait_rise(1);
        bus_write(8'h04, 32'd20);
        hi = 2;
        while (pwm_out[1] && hi < LIM) begin hi++; @(negedge clk); end
        check("R8", "period in progress keeps old duty", hi, 404);
        measure(1, hi, lo);
        check("R8", "new duty after wrap", hi, 84);
        check("R8", "period unchanged by duty write", hi + lo, 1024);
    endtask

    task automatic t_freeze();
        logic [31:0] c1, c2, c3;
        int hi, lo;
        bus_write(8'h50, 32'h0000_0003);
        bus_read(8'h58, c1);
        check("R7", "outputs low when disabled", 32'(pwm_out), 0);
        repeat (50) @(negedge clk);
        bus_read(8'h58, c2);
        check("R7", "counter frozen", c2, c1);
        check("R7", "outputs still low", 32'(pwm_out), 0);
        bus_write(8'h50, 32'h0000_0203);
        bus_read(8'h58, c3);
        check("R7", "resume near frozen value", 32'(((c3 - c1) & 32'hFF) <= 2), 1);
        measure(1, hi, lo);
        check("R7", "high time after resume", hi, 84);
        check("R7", "period after resume", hi + lo, 1024);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_unmapped();
        t_base_patterns();
        t_full_duty();
        t_prescale();
        t_deferred();
        t_freeze();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule